// File: doc/BRIEF.md
# PS/2 Host Port with Sticky Event Flags

This block is the host end of a two-wire PS/2 link. It receives 11-bit frames from a keyboard or mouse and places each data byte in a receive register. It also sends command bytes to the device. To send, it pulls the clock low, issues a request-to-send, shifts the byte out and checks for the device's acknowledge. A watchdog abandons any packet whose device clock stops part way through.

Every outcome of the serial engine raises its own sticky flag in a status register. Those outcomes are a good receive, a bad receive, an overrun, transmit acknowledged, transmit not acknowledged, and a timeout. Software clears a flag by writing a one to the matching bit of a separate clear register. The interrupt output is high while any flag is set. The line drivers are split into input, output and output-enable signals, one set for the clock line and one for the data line. An external pad or the bench forms the wired-AND line from them.

Top module: `ps2_host_port`

## Requirements
- R1: After reset the status register (offset 0x10) reads 0x00, `irq_o` is low and neither `ps2_clk_oe_o` nor `ps2_dat_oe_o` is asserted.
- R2: A frame with a low start bit, eight data bits sent LSB first, an odd parity bit and a high stop bit places the byte at offset 0x00 and sets status bit 2.
- R3: A valid frame that arrives while the previous byte at 0x00 has not been read sets status bit 4 and replaces the byte. After a read of 0x00 the next frame does not set bit 4.
- R4: A frame with a high start bit, even parity or a low stop bit sets status bit 3 and leaves the byte at 0x00 unchanged.
- R5: A write to offset 0x04 while the engine is idle holds `ps2_clk_oe_o` high for exactly INHIBIT_CYCLES cycles. The block then releases the clock and pulls the data line low (start bit). After each device clock fall it presents the next bit: data LSB first, then odd parity, then a released stop bit.
- R6: On the device clock fall that follows the stop bit, a low data line sets status bit 5 and a high data line sets status bit 6.
- R7: If WDOG_CYCLES system cycles pass with no device clock fall while a frame is being received or sent, status bit 7 is set. The engine then releases both lines and returns to idle, and it can receive the next frame normally.
- R8: A write to 0x14 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. A write to 0x10 has no effect. Status bits 0 and 1 always read 0.
- R9: When an event and a clear write hit the same flag in the same cycle, the flag is set.
- R10: `irq_o` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (marks receive data consumed) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | High while any status flag is set |
| ps2_clk_i | input | 1 | Device clock line as sensed |
| ps2_dat_i | input | 1 | Device data line as sensed |
| ps2_clk_o | output | 1 | Clock drive level (always low) |
| ps2_clk_oe_o | output | 1 | Pull clock line low |
| ps2_dat_o | output | 1 | Data drive level (always low) |
| ps2_dat_oe_o | output | 1 | Pull data line low |

## Verification
A frame counter in the engine that is off by one shows up within one frame. Either an error flag is raised instead of the full flag, or a wrong byte or a shifted parity or stop bit appears on the data line. A lost unread marker shows as a missing or spurious overrun on the second frame. A wrong inhibit count or a wrong watchdog limit changes the measured hold time, or it changes whether bit 7 appears within one watchdog window. Flag-update faults show on the next status read and on `irq_o`, one cycle after the event or the clear write.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;
  localparam int FRAME_BITS = 11;
  localparam int DATA_BITS  = 8;
  localparam int FLAG_LO    = 2;
  localparam int FLAG_HI    = 7;
  localparam int FLAG_N     = FLAG_HI - FLAG_LO + 1;

  localparam int ADR_RXD  = 'h00;
  localparam int ADR_TXD  = 'h04;
  localparam int ADR_STAT = 'h10;
  localparam int ADR_CLR  = 'h14;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_INHIBIT, ST_TX} eng_state_e;

  typedef struct packed {
    logic wdt;
    logic tx_nak;
    logic tx_ack;
    logic rx_bad;
    logic rx_ok;
  } eng_evt_t;
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_async_i,
  input  logic dat_async_i,
  output logic dat_o,
  output logic fall_o
);
  logic [STAGES:0]   clk_q;
  logic [STAGES-1:0] dat_q;

  // lines idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= '1;
      dat_q <= '1;
    end else begin
      clk_q <= {clk_q[STAGES-1:0], clk_async_i};
      dat_q <= {dat_q[STAGES-2:0], dat_async_i};
    end
  end

  assign dat_o  = dat_q[STAGES-1];
  assign fall_o = clk_q[STAGES] & ~clk_q[STAGES-1];
endmodule

// File: rtl/ps2_wdog.sv
module ps2_wdog #(
  parameter int unsigned LIMIT = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || kick_i)   cnt_q <= '0;
    else if (!expire_o)          cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !kick_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ps2_engine.sv
module ps2_engine
  import ps2_host_pkg::*;
#(
  parameter int unsigned INHIBIT_CYCLES = 64,
  parameter int unsigned WDOG_CYCLES    = 512
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fall_i,
  input  logic                 dat_i,
  input  logic                 tx_start_i,
  input  logic [DATA_BITS-1:0] tx_byte_i,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output eng_evt_t             evt_o,
  output logic                 clk_oe_o,
  output logic                 dat_oe_o
);
  localparam int unsigned IW = (INHIBIT_CYCLES > 1) ? $clog2(INHIBIT_CYCLES) : 1;
  localparam int unsigned BW = $clog2(FRAME_BITS + 1);

  eng_state_e            state_q;
  logic [BW-1:0]         cnt_q;
  logic [IW-1:0]         inh_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [FRAME_BITS-1:0] nf;
  eng_evt_t              evt_q;
  logic                  wdt_exp;
  logic                  last_bit;

  assign nf       = {dat_i, sh_q[FRAME_BITS-1:1]};
  assign last_bit = (cnt_q == BW'(FRAME_BITS - 1));

  ps2_wdog #(.LIMIT(WDOG_CYCLES)) i_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_RX || state_q == ST_TX),
    .kick_i   (fall_i),
    .expire_o (wdt_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      inh_q   <= '0;
      sh_q    <= '1;
      evt_q   <= '0;
    end else begin
      evt_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (tx_start_i) begin
            sh_q    <= {1'b1, ~^tx_byte_i, tx_byte_i, 1'b0};
            inh_q   <= '0;
            state_q <= ST_INHIBIT;
          end else if (fall_i) begin
            sh_q    <= nf;
            cnt_q   <= BW'(1);
            state_q <= ST_RX;
          end
        end
        ST_RX: begin
          if (wdt_exp) begin
            evt_q.wdt <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (fall_i) begin
            sh_q  <= nf;
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) begin
              state_q <= ST_IDLE;
              // start low, odd parity over data+parity, stop high
              if (!nf[0] && (^nf[FRAME_BITS-2:1]) && nf[FRAME_BITS-1]) evt_q.rx_ok <= 1'b1;
              else evt_q.rx_bad <= 1'b1;
            end
          end
        end
        ST_INHIBIT: begin
          if (inh_q == IW'(INHIBIT_CYCLES - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_TX;
          end else begin
            inh_q <= inh_q + 1'b1;
          end
        end
        ST_TX: begin
          if (wdt_exp) begin
            evt_q.wdt <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (fall_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) begin
              state_q <= ST_IDLE;
              if (!dat_i) evt_q.tx_ack <= 1'b1;
              else        evt_q.tx_nak <= 1'b1;
            end else begin
              sh_q <= {1'b1, sh_q[FRAME_BITS-1:1]};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rx_byte_o = sh_q[DATA_BITS:1];
  assign evt_o     = evt_q;
  assign clk_oe_o  = (state_q == ST_INHIBIT);
  assign dat_oe_o  = (state_q == ST_TX) && !sh_q[0];
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2_host_pkg::*;
#(
  parameter int unsigned ADDR_W         = 5,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned INHIBIT_CYCLES = 64,
  parameter int unsigned WDOG_CYCLES    = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_o,
  output logic              ps2_clk_oe_o,
  output logic              ps2_dat_o,
  output logic              ps2_dat_oe_o
);
  logic                 dat_s, fall_s, busy;
  logic [DATA_BITS-1:0] rx_byte, rx_data_q;
  logic                 rx_unread_q;
  eng_evt_t             evt;
  logic [FLAG_N-1:0]    flag_q, flag_set, flag_clr;
  logic                 sel_rxd, sel_txd, sel_stat, sel_clr, rd_rxd;

  assign sel_rxd  = (addr_i == ADDR_W'(ADR_RXD));
  assign sel_txd  = (addr_i == ADDR_W'(ADR_TXD));
  assign sel_stat = (addr_i == ADDR_W'(ADR_STAT));
  assign sel_clr  = (addr_i == ADDR_W'(ADR_CLR));
  assign rd_rxd   = re_i && sel_rxd;

  ps2_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clk_async_i (ps2_clk_i),
    .dat_async_i (ps2_dat_i),
    .dat_o       (dat_s),
    .fall_o      (fall_s)
  );

  ps2_engine #(
    .INHIBIT_CYCLES (INHIBIT_CYCLES),
    .WDOG_CYCLES    (WDOG_CYCLES)
  ) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall_s),
    .dat_i      (dat_s),
    .tx_start_i (we_i && sel_txd && !busy),
    .tx_byte_i  (wdata_i),
    .busy_o     (busy),
    .rx_byte_o  (rx_byte),
    .evt_o      (evt),
    .clk_oe_o   (ps2_clk_oe_o),
    .dat_oe_o   (ps2_dat_oe_o)
  );

  // flag vector index k maps to status bit FLAG_LO+k
  assign flag_set = {evt.wdt, evt.tx_nak, evt.tx_ack,
                     evt.rx_ok && rx_unread_q && !rd_rxd,
                     evt.rx_bad, evt.rx_ok};
  assign flag_clr = (we_i && sel_clr) ? wdata_i[FLAG_HI:FLAG_LO] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q      <= '0;
      rx_data_q   <= '0;
      rx_unread_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (evt.rx_ok) begin
        rx_data_q   <= rx_byte;
        rx_unread_q <= 1'b1;
      end else if (rd_rxd) begin
        rx_unread_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_rxd)       rdata_o = rx_data_q;
    else if (sel_stat) rdata_o[FLAG_HI:FLAG_LO] = flag_q;
  end

  assign irq_o     = |flag_q;
  assign ps2_clk_o = 1'b0;
  assign ps2_dat_o = 1'b0;
endmodule

// File: rtl/ps2_host_port_chk.sv
module ps2_host_port_chk
  import ps2_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [FLAG_N-1:0] set_i,
  input logic [FLAG_N-1:0] flags_i,
  input logic [4:0]        evt_i
);
  logic clr_wr;
  assign clr_wr = we_i && (addr_i == ADDR_W'(ADR_CLR));

  // R8: low status bits read zero
  a_r8_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADR_STAT)) |-> (rdata_o[1:0] == 2'b00));

  // R9: an event always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_i & $past(set_i)) == $past(set_i)));

  // R8: written ones clear when nothing sets
  a_r8_clear_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && set_i == '0) |=> ((flags_i & $past(wdata_i[FLAG_HI:FLAG_LO])) == '0));

  // R8: flags are sticky without a clear write
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  // R7: one engine outcome at a time
  a_r7_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_i));

  // R3: overflow only with a good frame
  a_r3_ovf_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[4-FLAG_LO] |-> set_i[2-FLAG_LO]);
endmodule

bind ps2_host_port ps2_host_port_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .set_i   (flag_set),
  .flags_i (flag_q),
  .evt_i   (evt)
);

// File: tb/test_ps2_host_port.sv
`timescale 1ns/1ps
module test_ps2_host_port;
  localparam int INH  = 40;
  localparam int WDT  = 100;
  localparam int HALF = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, clk_o, clk_oe, dat_o, dat_oe;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic ps2_clk, ps2_dat;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_flags = '0, exp_rxd = '0;
  bit exp_unread = 0;

  always #2.5 clk = ~clk;

  assign ps2_clk = dev_clk & ~clk_oe;
  assign ps2_dat = dev_dat & ~dat_oe;

  ps2_host_port #(.INHIBIT_CYCLES(INH), .WDOG_CYCLES(WDT)) i_ps2_host_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .ps2_clk_o(clk_o), .ps2_clk_oe_o(clk_oe),
    .ps2_dat_o(dat_o), .ps2_dat_oe_o(dat_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_start,
                                           input bit bad_par, input bit bad_stop);
    return {~bad_stop, (~^b) ^ bad_par, b, bad_start};
  endfunction

  task automatic dev_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      dev_dat = f[i]; tick(HALF);
      dev_clk = 1'b0; tick(HALF);
      dev_clk = 1'b1;
    end
    dev_dat = 1'b1; tick(HALF);
  endtask

  task automatic model_rx(input logic [7:0] b, input bit ok);
    if (ok) begin
      if (exp_unread) exp_flags |= 8'h10;
      exp_flags |= 8'h04; exp_rxd = b; exp_unread = 1;
    end else exp_flags |= 8'h08;
  endtask

  task automatic chk_status(input string req);
    logic [7:0] d;
    bus_rd(5'h10, d);
    check(req, d, exp_flags);
    check("R10", irq, exp_flags != 0);
  endtask

  task automatic chk_rxd(input string req);
    logic [7:0] d;
    bus_rd(5'h00, d);
    check(req, d, exp_rxd);
    exp_unread = 0;
  endtask

  task automatic clr(input logic [7:0] m);
    bus_wr(5'h14, m);
    exp_flags &= ~(m & 8'hFC);
  endtask

  // device side of a host-to-device byte
  task automatic dev_accept(input logic [7:0] b, input bit ack);
    int n = 0;
    logic [9:0] got;
    wait (clk_oe);
    forever begin
      @(negedge clk);
      if (clk_oe) n++; else break;
    end
    check("R5 inhibit length", n, INH);
    check("R5 start bit driven", dat_oe, 1);
    for (int k = 0; k < 10; k++) begin
      tick(HALF); dev_clk = 1'b0;
      tick(HALF); got[k] = ~dat_oe; dev_clk = 1'b1;
    end
    check("R5 data bits", got[7:0], b);
    check("R5 parity", got[8], ~^b);
    check("R5 stop released", got[9], 1);
    tick(HALF); dev_dat = ~ack;
    tick(2); dev_clk = 1'b0;
    tick(HALF); dev_clk = 1'b1; dev_dat = 1'b1;
    tick(HALF);
    exp_flags |= ack ? 8'h20 : 8'h40;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [7:0] d;
    bit saw_irq;
    tick(3); rst_n = 1'b1; tick(2);

    // R1
    check("R1 irq", irq, 0);
    check("R1 clk_oe", clk_oe, 0);
    check("R1 dat_oe", dat_oe, 0);
    chk_status("R1 status");

    // R2
    dev_bits(mk_frame(8'hA5, 0, 0, 0), 11); model_rx(8'hA5, 1);
    chk_status("R2 full");
    chk_rxd("R2 data");
    clr(8'h04); chk_status("R8 clear full");

    // R3
    dev_bits(mk_frame(8'h3C, 0, 0, 0), 11); model_rx(8'h3C, 1);
    dev_bits(mk_frame(8'hC3, 0, 0, 0), 11); model_rx(8'hC3, 1);
    chk_status("R3 overflow");
    chk_rxd("R3 newest byte");
    clr(8'hFC);
    dev_bits(mk_frame(8'h11, 0, 0, 0), 11); model_rx(8'h11, 1);
    chk_status("R3 no overflow after read");
    chk_rxd("R3 data");
    clr(8'hFC);

    // R4
    dev_bits(mk_frame(8'h55, 1, 0, 0), 11); model_rx(8'h55, 0);
    chk_status("R4 bad start");
    chk_rxd("R4 data kept");
    clr(8'h08);
    dev_bits(mk_frame(8'h55, 0, 1, 0), 11); model_rx(8'h55, 0);
    chk_status("R4 bad parity");
    clr(8'h08);
    dev_bits(mk_frame(8'h55, 0, 0, 1), 11); model_rx(8'h55, 0);
    chk_status("R4 bad stop");
    chk_rxd("R4 data kept");
    clr(8'h08);

    // R8
    dev_bits(mk_frame(8'h9E, 0, 0, 0), 11); model_rx(8'h9E, 1);
    clr(8'h00); chk_status("R8 zero write");
    bus_wr(5'h10, 8'hFF); chk_status("R8 status write ignored");
    clr(8'h0B); chk_status("R8 other bits");
    chk_rxd("R2 data");
    clr(8'h04); chk_status("R8 cleared");

    // R5 / R6
    fork
      bus_wr(5'h04, 8'h96);
      dev_accept(8'h96, 1);
    join
    chk_status("R6 ack");
    clr(8'h20);
    fork
      bus_wr(5'h04, 8'h01);
      dev_accept(8'h01, 0);
    join
    chk_status("R6 no ack");
    clr(8'h40);

    // R7 receive stall
    dev_bits(mk_frame(8'hFF, 0, 0, 0), 5);
    tick(WDT + 20);
    exp_flags |= 8'h80;
    chk_status("R7 rx timeout");
    clr(8'h80);
    dev_bits(mk_frame(8'h7E, 0, 0, 0), 11); model_rx(8'h7E, 1);
    chk_status("R7 recovers");
    chk_rxd("R7 data");
    clr(8'h04);

    // R7 transmit stall
    bus_wr(5'h04, 8'h33);
    tick(INH + WDT + 30);
    exp_flags |= 8'h80;
    check("R7 lines released", {clk_oe, dat_oe}, 0);
    chk_status("R7 tx timeout");
    clr(8'h80);

    // R9: clear held on bit 2 while a frame lands
    @(negedge clk); addr = 5'h14; wdata = 8'h04; we = 1'b1;
    saw_irq = 0;
    fork
      dev_bits(mk_frame(8'h42, 0, 0, 0), 11);
      for (int c = 0; c < 11 * 2 * HALF + 2 * HALF; c++) begin
        @(negedge clk); if (irq) saw_irq = 1;
      end
    join
    @(negedge clk); we = 1'b0;
    exp_rxd = 8'h42; exp_unread = 1;
    check("R9 set wins", saw_irq, 1);
    chk_status("R9 cleared after");
    chk_rxd("R9 data");

    report();
  end
endmodule